// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two unsigned or two's-complement operands and a carry-in. It produces the sum, the carry-out and a signed overflow flag. It is purely combinational, and its width is a parameter. The width must be a whole multiple of four, and it defaults to sixteen.

The operand bits are split into four-bit slices. Inside each slice:

- Every bit forms a generate term (operand AND) and a propagate term (operand OR).
- The slice resolves its own carries from those terms and its incoming carry in flattened sum-of-products form.
- The slice reports one slice generate term and one slice propagate term.

A second-level unit takes the slice terms and the external carry-in and forms the carry into every slice directly. As a result, no carry travels serially from one slice to the next. Each sum bit is the operand XOR combined with the carry arriving at that bit.

Top module: `cla2_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i`, treating the operands as unsigned.
- R2: `cout_o` equals bit WIDTH of `a_i + b_i + cin_i`, which is 1 exactly when the unsigned result exceeds 2^WIDTH - 1.
- R3: `ovf_o` is 1 exactly when the two operands have equal most significant bits and `sum_o` has a different most significant bit.
- R4: With `cin_i` = 1, the result is one greater than with `cin_i` = 0 for the same operands. An all-ones `a_i` plus zero plus carry-in gives `sum_o` = 0 and `cout_o` = 1.
- R5: A carry formed in one four-bit slice reaches the next slice correctly. For example, 0x00FF + 0x0001 gives 0x0100, and 0x0FF0 + 0x0010 gives 0x1000.
- R6: A carry propagates through every slice to the top. For example, 0xFFFF + 0x0000 + 1 gives 0x0000 with carry-out, and 0x7FFF + 0x0001 gives 0x8000 with overflow.
- R7: A bit position where both operand bits are 1 yields a sum bit equal to the carry arriving at that position, not 1. For example, 0x0001 + 0x0001 gives 0x0002, and 0x5555 + 0x5555 gives 0xAAAA.
- R8: With WIDTH set to 8, R1 to R3 hold for every combination of operands and carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |
| ovf_o | output | 1 | Two's-complement overflow |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Sum formed from the OR propagate.** Bit positions where both operands are 1 are the case where the OR propagate and the XOR half-sum differ. A design that built the sum from the OR propagate would set those sum bits wrongly.
- **Slice boundaries.** Carries that must cross one or more slice boundaries would arrive as 0 in a design with a wrong second-level product term.
- **All-ones chains.** These expose a dropped carry-in term, because the external carry must pass through every slice.
- **Overflow at the sign bit.** The overflow cases at the sign boundary separate the correct carry-in versus carry-out comparison from one that uses the wrong bit.

An exhaustive sweep at eight bits and random vectors at sixteen bits cover the rest.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned BLK = 4;
endpackage

// File: rtl/cla_block.sv
module cla_block
  import cla_pkg::*;
(
  input  logic [BLK-1:0] g_i,
  input  logic [BLK-1:0] p_i,
  input  logic           cin_i,
  output logic [BLK-1:0] c_o,
  output logic           gblk_o,
  output logic           pblk_o
);
  logic prod;
  logic term;
  logic acc;

  always_comb begin
    c_o = '0;
    for (int i = 0; i < BLK; i++) begin
      prod = cin_i;
      for (int j = 0; j < i; j++) prod = prod & p_i[j];
      acc = prod;
      for (int j = 0; j < i; j++) begin
        term = g_i[j];
        for (int k = j + 1; k < i; k++) term = term & p_i[k];
        acc = acc | term;
      end
      c_o[i] = acc;
    end
    acc = 1'b0;
    for (int j = 0; j < BLK; j++) begin
      term = g_i[j];
      for (int k = j + 1; k < BLK; k++) term = term & p_i[k];
      acc = acc | term;
    end
    gblk_o = acc;
    pblk_o = &p_i;
  end

  // Slice carry-out from the last bit equals the slice-level terms.
  always_comb begin
    assert_blkout_R5: assert ((g_i[BLK-1] | (p_i[BLK-1] & c_o[BLK-1])) ==
                              (gblk_o | (pblk_o & cin_i)))
      else $error("slice carry-out mismatch");
  end
endmodule

// File: rtl/cla_group_gen.sv
module cla_group_gen #(
  parameter int unsigned NB = 4
) (
  input  logic [NB-1:0] gblk_i,
  input  logic [NB-1:0] pblk_i,
  input  logic          cin_i,
  output logic [NB:0]   cblk_o
);
  logic prod;
  logic term;
  logic acc;

  always_comb begin
    cblk_o = '0;
    for (int k = 0; k <= NB; k++) begin
      prod = cin_i;
      for (int j = 0; j < k; j++) prod = prod & pblk_i[j];
      acc = prod;
      for (int j = 0; j < k; j++) begin
        term = gblk_i[j];
        for (int m = j + 1; m < k; m++) term = term & pblk_i[m];
        acc = acc | term;
      end
      cblk_o[k] = acc;
    end
  end

  // Flattened carries agree with the recursive form, slice by slice.
  always_comb begin
    assert_cin_R4: assert (cblk_o[0] == cin_i) else $error("carry-in lost");
    for (int k = 0; k < NB; k++) begin
      assert_blkcarry_R5: assert (cblk_o[k+1] ==
                                  (gblk_i[k] | (pblk_i[k] & cblk_o[k])))
        else $error("slice carry %0d mismatch", k + 1);
    end
  end
endmodule

// File: rtl/cla2_adder.sv
module cla2_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int unsigned NB = WIDTH / BLK;

  logic [WIDTH-1:0] gen_bit;
  logic [WIDTH-1:0] prop_bit;
  logic [WIDTH-1:0] half_sum;
  logic [WIDTH-1:0] carry_bit;
  logic [NB-1:0]    gblk;
  logic [NB-1:0]    pblk;
  logic [NB:0]      cblk;

  assign gen_bit  = a_i & b_i;
  assign prop_bit = a_i | b_i;
  assign half_sum = a_i ^ b_i;

  for (genvar s = 0; s < NB; s++) begin : g_slice
    cla_block u_blk (
      .g_i    (gen_bit[s*BLK +: BLK]),
      .p_i    (prop_bit[s*BLK +: BLK]),
      .cin_i  (cblk[s]),
      .c_o    (carry_bit[s*BLK +: BLK]),
      .gblk_o (gblk[s]),
      .pblk_o (pblk[s])
    );
  end

  cla_group_gen #(.NB(NB)) u_gen (
    .gblk_i (gblk),
    .pblk_i (pblk),
    .cin_i  (cin_i),
    .cblk_o (cblk)
  );

  assign sum_o  = half_sum ^ carry_bit;
  assign cout_o = cblk[NB];
  assign ovf_o  = carry_bit[WIDTH-1] ^ cblk[NB];

  always_comb begin
    assert_sum_R1: assert ({cout_o, sum_o} ==
                           ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("sum mismatch");
    assert_cout_R2: assert (cout_o == ((a_i[WIDTH-1] & b_i[WIDTH-1]) |
                            ((a_i[WIDTH-1] ^ b_i[WIDTH-1]) & ~sum_o[WIDTH-1])))
      else $error("carry-out mismatch");
    assert_ovf_R3: assert (ovf_o == ((a_i[WIDTH-1] == b_i[WIDTH-1]) &&
                                     (sum_o[WIDTH-1] != a_i[WIDTH-1])))
      else $error("overflow mismatch");
  end
endmodule

// File: tb/sim_cla2_adder.sv
`timescale 1ns/1ps
module sim_cla2_adder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] a16, b16, s16;
  logic        c16, co16, ov16;
  logic [7:0]  a8, b8, s8;
  logic        c8, co8, ov8;

  cla2_adder #(.WIDTH(16)) u0 (
    .a_i(a16), .b_i(b16), .cin_i(c16),
    .sum_o(s16), .cout_o(co16), .ovf_o(ov16));
  cla2_adder #(.WIDTH(8)) u1 (
    .a_i(a8), .b_i(b8), .cin_i(c8),
    .sum_o(s8), .cout_o(co8), .ovf_o(ov8));

  task automatic check16(input logic [15:0] a, input logic [15:0] b,
                         input logic ci, input string tag);
    logic [16:0] full;
    logic        eov;
    @(posedge clk);
    a16 = a; b16 = b; c16 = ci;
    @(negedge clk);
    full = {1'b0, a} + {1'b0, b} + {16'd0, ci};
    eov  = (a[15] == b[15]) && (full[15] != a[15]);
    checks++;
    if (s16 !== full[15:0] || co16 !== full[16] || ov16 !== eov) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%b: got sum=%h cout=%b ovf=%b exp sum=%h cout=%b ovf=%b",
               tag, a, b, ci, s16, co16, ov16, full[15:0], full[16], eov);
    end
  endtask

  task automatic t_reset_state();
    @(posedge clk); rst = 1'b0;
    check16(16'h0000, 16'h0000, 1'b0, "R1 zero operands");
  endtask

  task automatic t_carry_in();
    check16(16'h1234, 16'h4321, 1'b0, "R4 no carry-in");
    check16(16'h1234, 16'h4321, 1'b1, "R4 carry-in adds one");
    check16(16'hFFFF, 16'h0000, 1'b1, "R4 all-ones plus carry-in");
  endtask

  task automatic t_slice_boundary();
    check16(16'h00FF, 16'h0001, 1'b0, "R5 carry across two slices");
    check16(16'h0FF0, 16'h0010, 1'b0, "R5 carry from slice 1");
    check16(16'h000F, 16'h0000, 1'b1, "R5 carry-in crossing slice 0");
    check16(16'h0F00, 16'h0100, 1'b0, "R5 carry into slice 3");
  endtask

  task automatic t_full_chain();
    check16(16'hFFFF, 16'h0001, 1'b0, "R6 carry through all slices");
    check16(16'h7FFF, 16'h0001, 1'b0, "R6 R3 positive overflow");
    check16(16'h8000, 16'h8000, 1'b0, "R3 negative overflow with cout R2");
    check16(16'h8000, 16'h7FFF, 1'b1, "R2 mixed signs carry-out");
    check16(16'hFFFF, 16'hFFFF, 1'b1, "R2 maximum inputs");
  endtask

  task automatic t_both_ones();
    check16(16'h0001, 16'h0001, 1'b0, "R7 both bits set");
    check16(16'h5555, 16'h5555, 1'b0, "R7 alternating both set");
    check16(16'hAAAA, 16'hAAAA, 1'b1, "R7 both set with carry-in");
  endtask

  task automatic t_random16();
    for (int n = 0; n < 1500; n++)
      check16(16'($urandom), 16'($urandom), 1'($urandom), "R1 R2 R3 random");
  endtask

  task automatic t_exhaustive8();
    int bad = 0;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        for (int ci = 0; ci < 2; ci++) begin
          logic [8:0] full;
          logic       eov;
          @(posedge clk);
          a8 = 8'(a); b8 = 8'(b); c8 = 1'(ci);
          @(negedge clk);
          full = 9'(a) + 9'(b) + 9'(ci);
          eov  = (a8[7] == b8[7]) && (full[7] != a8[7]);
          checks++;
          if (s8 !== full[7:0] || co8 !== full[8] || ov8 !== eov) begin
            errors++;
            if (bad < 10)
              $display("FAIL R8 a=%h b=%h cin=%0d: got %b/%h/%b exp %b/%h/%b",
                       a8, b8, ci, co8, s8, ov8, full[8], full[7:0], eov);
            bad++;
          end
        end
      end
    end
  endtask

  initial begin
    a16 = '0; b16 = '0; c16 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    repeat (2) @(posedge clk);
    t_reset_state();
    t_carry_in();
    t_slice_boundary();
    t_full_chain();
    t_both_ones();
    t_random16();
    t_exhaustive8();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule